// File: doc/BRIEF.md
# Serial Pattern Trigger Detector

This block watches a one-bit serial data line and pulses a trigger output for one cycle when the most recently received bits equal a programmed pattern. Bits reach the shift register in one of two ways. In external-clock mode, a selected edge of an incoming clock line samples the data. In internal mode, a phase-accumulator bit-rate generator running on the system clock samples the data. In external-clock mode, a chip-select style qualifier can gate sampling. The qualifier is built from several level inputs, each programmed as high, low or don't-care, and combined with AND or OR.

The pattern is compared after every sampled bit. In external-clock mode the comparison can instead wait for a chosen edge of a separate latch input. A per-bit mask excludes pattern bits from the comparison, and a length setting picks how many recent bits take part. After reset or a re-arm, the trigger stays suppressed until at least that many bits have arrived. All line inputs (clock, data, latch, qualifiers) are level signals that pass through two-flop synchronizers of equal depth, so the relative timing between them is preserved.

Top module: `serial_pattern_trigger`

## Requirements
- R1: With `cfg_ext_clk_en`=0, a sample is taken each time the accumulator (width ACC_W) carries after adding `cfg_rate_inc`. With ACC_W=32 and an increment of 2^30 this gives a sample every 4 cycles, and with 2^29 a sample every 8 cycles. External clock, latch and qualifier inputs have no effect in this mode.
- R2: With `cfg_ext_clk_en`=1, a bit is sampled on each rising edge of `ext_clk` when `cfg_clk_falling`=0, and on each falling edge when it is 1. The other edge samples nothing.
- R3: With `cfg_qual_en`=1 in external-clock mode, a clock edge samples only while the qualifier is true, and a blocked edge leaves the shift register unchanged. With `cfg_qual_en`=0, every clock edge samples.
- R4: Qualifier k uses bits [2k+1:2k] of `cfg_qual_sel`: 2'b01 is true when input k is high, 2'b10 is true when it is low, and 2'b00 or 2'b11 means don't-care. With `cfg_qual_or`=0 (AND), the qualifier is true only when every non-don't-care input matches.
- R5: With `cfg_qual_or`=1 (OR), the qualifier is true when any non-don't-care input matches.
- R6: When every qualifier is set to don't-care, the qualifier is true under both AND and OR.
- R7: Bits enter bit 0 and shift toward higher bits, so the newest bit is bit 0 and pattern bit `cfg_len`-1 corresponds to the oldest bit in the window. Only bits below `cfg_len` whose `cfg_mask` bit is 1 are compared; mask bit 0 means don't-care.
- R8: With `cfg_latch_en`=1 in external-clock mode, the compare happens only on the selected `ext_latch` edge (rising when `cfg_latch_falling`=0, falling when 1). If a latch edge falls in the same cycle as a sampling edge, the compare uses the contents from before that bit.
- R9: With the latch disabled, or in internal mode, the compare happens once after each sampled bit, using the register that includes the new bit.
- R10: A match drives `trig_out` high for exactly one cycle. No trigger occurs until at least `cfg_len` bits have been sampled since the last reset or `rearm`. `rearm` clears the received bits and the bit count.
- R11: After reset `trig_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rearm | input | 1 | Clears received bits and the bit count |
| cfg_ext_clk_en | input | 1 | 1: sample on external clock, 0: internal bit rate |
| cfg_clk_falling | input | 1 | Sampling edge of `ext_clk`: 0 rising, 1 falling |
| cfg_rate_inc | input | ACC_W | Phase increment of the bit-rate generator |
| cfg_qual_en | input | 1 | Enable qualifier gating of sampling |
| cfg_qual_sel | input | 2*NQ | Per-qualifier setting (01 high, 10 low, 00/11 don't-care) |
| cfg_qual_or | input | 1 | Qualifier logic: 0 AND, 1 OR |
| cfg_latch_en | input | 1 | Compare on latch edge instead of after every bit |
| cfg_latch_falling | input | 1 | Latch edge: 0 rising, 1 falling |
| cfg_pattern | input | PAT_W | Pattern to match |
| cfg_mask | input | PAT_W | 1 = compare this bit, 0 = don't-care |
| cfg_len | input | $clog2(PAT_W+1) | Number of recent bits in the window (1..PAT_W) |
| ext_clk | input | 1 | External sampling clock line |
| ext_data | input | 1 | Serial data line |
| ext_latch | input | 1 | Latch line that times the compare |
| ext_qual | input | NQ | Qualifier lines |
| trig_out | output | 1 | One-cycle trigger pulse |

## Verification
The critical coincidence is a latch edge that lands in the same cycle as a sampling clock edge. Both lines pass through identical synchronizers, so the bench raises `ext_clk` and `ext_latch` together on one falling system-clock edge. This makes both edges appear in the same internal cycle. The bench first loads the window so that it matches before the new bit and no longer matches after it. A single trigger therefore shows that the compare used the contents from before the bit. A follow-up latch edge without a trigger confirms that the new bit did land.

// File: rtl/spt_pkg.sv
package spt_pkg;
  typedef enum logic [1:0] {
    QSEL_IGNORE  = 2'b00,
    QSEL_HIGH    = 2'b01,
    QSEL_LOW     = 2'b10,
    QSEL_IGNORE2 = 2'b11
  } qual_sel_e;
endpackage

// File: rtl/spt_sync.sv
module spt_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] lvl_prev
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta     <= '0;
      lvl      <= '0;
      lvl_prev <= '0;
    end else begin
      meta     <= din;
      lvl      <= meta;
      lvl_prev <= lvl;
    end
  end
endmodule

// File: rtl/spt_rate_gen.sv
module spt_rate_gen #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [ACC_W-1:0] inc,
  output logic             strobe
);
  localparam logic [ACC_W-1:0] HALF = {1'b1, {(ACC_W-1){1'b0}}};

  logic [ACC_W-1:0] acc;
  logic [ACC_W:0]   sum;

  assign sum = {1'b0, acc} + {1'b0, inc};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc    <= '0;
      strobe <= 1'b0;
    end else if (run) begin
      acc    <= sum[ACC_W-1:0];
      strobe <= sum[ACC_W];
    end else begin
      strobe <= 1'b0;
    end
  end

  AST_STROBE_GAP: assert property (@(posedge clk) disable iff (rst)
    (strobe && run && inc <= HALF && $past(inc) <= HALF) |=> !strobe); // R1
endmodule

// File: rtl/spt_qualifier.sv
module spt_qualifier import spt_pkg::*; #(
  parameter int NQ = 3
) (
  input  logic [2*NQ-1:0] sel,
  input  logic [NQ-1:0]   lvl,
  input  logic            use_or,
  output logic            pass
);
  logic [NQ-1:0] care;
  logic [NQ-1:0] hit;

  for (genvar k = 0; k < NQ; k++) begin : g_q
    qual_sel_e s;
    assign s       = qual_sel_e'(sel[2*k +: 2]);
    assign care[k] = (s == QSEL_HIGH) || (s == QSEL_LOW);
    assign hit[k]  = (s == QSEL_HIGH) ? lvl[k] : ((s == QSEL_LOW) ? !lvl[k] : 1'b0);
  end

  always_comb begin
    if (care == '0)  pass = 1'b1;
    else if (use_or) pass = |(hit & care);
    else             pass = &(hit | ~care);
  end
endmodule

// File: rtl/serial_pattern_trigger.sv
module serial_pattern_trigger #(
  parameter int PAT_W = 32,
  parameter int NQ    = 3,
  parameter int ACC_W = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       rearm,
  input  logic                       cfg_ext_clk_en,
  input  logic                       cfg_clk_falling,
  input  logic [ACC_W-1:0]           cfg_rate_inc,
  input  logic                       cfg_qual_en,
  input  logic [2*NQ-1:0]            cfg_qual_sel,
  input  logic                       cfg_qual_or,
  input  logic                       cfg_latch_en,
  input  logic                       cfg_latch_falling,
  input  logic [PAT_W-1:0]           cfg_pattern,
  input  logic [PAT_W-1:0]           cfg_mask,
  input  logic [$clog2(PAT_W+1)-1:0] cfg_len,
  input  logic                       ext_clk,
  input  logic                       ext_data,
  input  logic                       ext_latch,
  input  logic [NQ-1:0]              ext_qual,
  output logic                       trig_out
);
  localparam int SW    = NQ + 3;
  localparam int CNT_W = $clog2(PAT_W + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(PAT_W);

  logic [SW-1:0] s_lvl, s_prev;
  logic          rate_strobe, qual_pass;
  logic          clk_hit, latch_hit, sample_fire, sample_q, cmp_evt;
  logic          win_match, armed;
  logic [PAT_W-1:0] shreg, len_mask;
  logic [CNT_W-1:0] bits_seen;

  spt_sync #(.W(SW)) u_sync (
    .clk(clk), .rst(rst),
    .din({ext_qual, ext_latch, ext_data, ext_clk}),
    .lvl(s_lvl), .lvl_prev(s_prev)
  );

  spt_rate_gen #(.ACC_W(ACC_W)) u_rate (
    .clk(clk), .rst(rst), .run(!cfg_ext_clk_en),
    .inc(cfg_rate_inc), .strobe(rate_strobe)
  );

  spt_qualifier #(.NQ(NQ)) u_qual (
    .sel(cfg_qual_sel), .lvl(s_lvl[SW-1:3]),
    .use_or(cfg_qual_or), .pass(qual_pass)
  );

  assign clk_hit   = cfg_clk_falling   ? (!s_lvl[0] && s_prev[0]) : (s_lvl[0] && !s_prev[0]);
  assign latch_hit = cfg_latch_falling ? (!s_lvl[2] && s_prev[2]) : (s_lvl[2] && !s_prev[2]);

  always_comb begin
    if (cfg_ext_clk_en) sample_fire = clk_hit && (!cfg_qual_en || qual_pass);
    else                sample_fire = rate_strobe;
  end

  assign cmp_evt = (cfg_ext_clk_en && cfg_latch_en) ? latch_hit : sample_q;

  always_comb begin
    for (int i = 0; i < PAT_W; i++) len_mask[i] = (CNT_W'(i) < cfg_len);
  end

  assign win_match = (((shreg ^ cfg_pattern) & cfg_mask & len_mask) == '0);
  assign armed     = (bits_seen >= cfg_len);

  always_ff @(posedge clk) begin
    if (rst || rearm) begin
      shreg     <= '0;
      bits_seen <= '0;
      sample_q  <= 1'b0;
      trig_out  <= 1'b0;
    end else begin
      if (sample_fire) begin
        shreg <= {shreg[PAT_W-2:0], s_lvl[1]};
        if (bits_seen != CNT_MAX) bits_seen <= bits_seen + 1'b1;
      end
      sample_q <= sample_fire;
      trig_out <= cmp_evt && win_match && armed;
    end
  end

  AST_QUAL_BLOCKS_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (cfg_ext_clk_en && cfg_qual_en && clk_hit && !qual_pass && !rearm) |=> $stable(shreg)); // R3
  AST_LATCH_ONLY: assert property (@(posedge clk) disable iff (rst)
    (cfg_ext_clk_en && cfg_latch_en && !latch_hit) |=> !trig_out); // R8
  AST_TRIG_FROM_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    (!(cfg_ext_clk_en && cfg_latch_en) && !sample_q) |=> !trig_out); // R9
  AST_TRIG_ARMED: assert property (@(posedge clk) disable iff (rst)
    (trig_out && $stable(cfg_len)) |-> (bits_seen >= cfg_len)); // R10
  AST_BITCNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (!$past(rearm) && bits_seen != $past(bits_seen)) |-> (bits_seen == $past(bits_seen) + 1'b1)); // R10
endmodule

// File: tb/tb_serial_pattern_trigger.sv
module tb_serial_pattern_trigger;
  localparam int PAT_W = 32;
  localparam int NQ    = 3;
  localparam int ACC_W = 32;

  logic clk = 1'b0, rst = 1'b1, rearm = 1'b0;
  logic cfg_ext_clk_en, cfg_clk_falling, cfg_qual_en, cfg_qual_or;
  logic cfg_latch_en, cfg_latch_falling;
  logic [ACC_W-1:0] cfg_rate_inc;
  logic [2*NQ-1:0]  cfg_qual_sel;
  logic [PAT_W-1:0] cfg_pattern, cfg_mask;
  logic [5:0]       cfg_len;
  logic ext_clk, ext_data, ext_latch;
  logic [NQ-1:0] ext_qual;
  logic trig_out;

  int n_chk = 0, n_fail = 0, trig_cnt = 0, dbl_cnt = 0;
  int cyc = 0, last_trig = 0, interval = 0;
  logic prev_trig = 1'b0, done = 1'b0;

  always #10 clk = ~clk;

  serial_pattern_trigger #(.PAT_W(PAT_W), .NQ(NQ), .ACC_W(ACC_W)) dut (
    .clk(clk), .rst(rst), .rearm(rearm),
    .cfg_ext_clk_en(cfg_ext_clk_en), .cfg_clk_falling(cfg_clk_falling),
    .cfg_rate_inc(cfg_rate_inc), .cfg_qual_en(cfg_qual_en),
    .cfg_qual_sel(cfg_qual_sel), .cfg_qual_or(cfg_qual_or),
    .cfg_latch_en(cfg_latch_en), .cfg_latch_falling(cfg_latch_falling),
    .cfg_pattern(cfg_pattern), .cfg_mask(cfg_mask), .cfg_len(cfg_len),
    .ext_clk(ext_clk), .ext_data(ext_data), .ext_latch(ext_latch),
    .ext_qual(ext_qual), .trig_out(trig_out)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (trig_out) begin
      trig_cnt  <= trig_cnt + 1;
      interval  <= cyc - last_trig;
      last_trig <= cyc;
      if (prev_trig) dbl_cnt <= dbl_cnt + 1;
    end
    prev_trig <= trig_out;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(input bit ext, input bit fall, input logic [31:0] pat,
                       input logic [31:0] msk, input int len);
    @(negedge clk);
    cfg_ext_clk_en = ext; cfg_clk_falling = fall; cfg_rate_inc = 32'h4000_0000;
    cfg_qual_en = 1'b0; cfg_qual_sel = '0; cfg_qual_or = 1'b0;
    cfg_latch_en = 1'b0; cfg_latch_falling = 1'b0;
    cfg_pattern = pat; cfg_mask = msk; cfg_len = 6'(len);
    ext_clk = fall; ext_latch = 1'b0; ext_data = 1'b0; ext_qual = '0;
    wait_n(6);
    rearm = 1'b1; wait_n(1); rearm = 1'b0;
    wait_n(4);
    trig_cnt = 0; dbl_cnt = 0;
  endtask

  task automatic send_bit(input logic b);
    ext_data = b;
    wait_n(3);
    ext_clk = !cfg_clk_falling;
    wait_n(3);
    ext_clk = cfg_clk_falling;
    wait_n(3);
  endtask

  task automatic send_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic latch_pulse();
    ext_latch = !cfg_latch_falling;
    wait_n(5);
    ext_latch = cfg_latch_falling;
    wait_n(5);
  endtask

  task automatic t_reset();
    chk(trig_out == 1'b0, "R11 reset trig_out", trig_out, 0);
  endtask

  task automatic t_basic();
    setup(1'b1, 1'b0, 32'hA5, 32'hFF, 8);
    send_bits(32'hA5 >> 1, 7);
    chk(trig_cnt == 0, "R7 no trigger on partial pattern", trig_cnt, 0);
    send_bit(1'b1);
    chk(trig_cnt == 1, "R9 R2 trigger after full rising-edge pattern", trig_cnt, 1);
  endtask

  task automatic t_length();
    setup(1'b1, 1'b0, 32'h0, 32'hFF, 8);
    send_bits(32'h0, 7);
    chk(trig_cnt == 0, "R10 suppressed before len bits", trig_cnt, 0);
    send_bit(1'b0);
    chk(trig_cnt == 1, "R10 trigger once len bits seen", trig_cnt, 1);
  endtask

  task automatic t_mask();
    setup(1'b1, 1'b0, 32'hFF, 32'hFF, 8);
    send_bits(32'hF0, 8);
    chk(trig_cnt == 0, "R7 full mask mismatch", trig_cnt, 0);
    setup(1'b1, 1'b0, 32'hFF, 32'hF0, 8);
    send_bits(32'hF0, 8);
    chk(trig_cnt == 1, "R7 masked bits ignored", trig_cnt, 1);
  endtask

  task automatic t_falling();
    setup(1'b1, 1'b1, 32'hD, 32'hF, 4);
    send_bits(32'hD, 4);
    chk(trig_cnt == 1, "R2 falling-edge sampling", trig_cnt, 1);
  endtask

  task automatic t_qual_and();
    setup(1'b1, 1'b0, 32'hF, 32'hF, 4);
    cfg_qual_en = 1'b1; cfg_qual_sel = 6'b00_10_01; cfg_qual_or = 1'b0;
    ext_qual = 3'b011; wait_n(4);
    send_bits(32'hF, 4);
    chk(trig_cnt == 0, "R4 AND blocked by one mismatch", trig_cnt, 0);
    ext_qual = 3'b001; wait_n(4);
    send_bit(1'b1); ext_qual = 3'b101;
    send_bits(32'h7, 3);
    chk(trig_cnt == 1, "R4 AND passes, X input ignored", trig_cnt, 1);
  endtask

  task automatic t_qual_or();
    setup(1'b1, 1'b0, 32'hF, 32'hF, 4);
    cfg_qual_en = 1'b1; cfg_qual_sel = 6'b00_10_01; cfg_qual_or = 1'b1;
    ext_qual = 3'b110; wait_n(4);
    send_bits(32'hF, 4);
    chk(trig_cnt == 0, "R5 OR blocked when none match", trig_cnt, 0);
    ext_qual = 3'b011; wait_n(4);
    send_bits(32'hF, 4);
    chk(trig_cnt == 1, "R5 OR passes on one match", trig_cnt, 1);
  endtask

  task automatic t_qual_allx();
    setup(1'b1, 1'b0, 32'hF, 32'hF, 4);
    cfg_qual_en = 1'b1; cfg_qual_sel = 6'b11_00_00; cfg_qual_or = 1'b1;
    ext_qual = 3'b000; wait_n(4);
    send_bits(32'hF, 4);
    chk(trig_cnt == 1, "R6 all don't-care true with OR", trig_cnt, 1);
    setup(1'b1, 1'b0, 32'hF, 32'hF, 4);
    cfg_qual_en = 1'b1; cfg_qual_sel = 6'b00_00_00; cfg_qual_or = 1'b0;
    ext_qual = 3'b101; wait_n(4);
    send_bits(32'hF, 4);
    chk(trig_cnt == 1, "R6 all don't-care true with AND", trig_cnt, 1);
  endtask

  task automatic t_qual_off();
    setup(1'b1, 1'b0, 32'hF, 32'hF, 4);
    cfg_qual_en = 1'b0; cfg_qual_sel = 6'b01_01_01;
    ext_qual = 3'b000; wait_n(4);
    send_bits(32'hF, 4);
    chk(trig_cnt == 1, "R3 qualifier disabled samples every edge", trig_cnt, 1);
  endtask

  task automatic t_latch();
    setup(1'b1, 1'b0, 32'hA, 32'hF, 4);
    cfg_latch_en = 1'b1; wait_n(2);
    send_bits(32'hA, 4);
    chk(trig_cnt == 0, "R8 no compare without latch edge", trig_cnt, 0);
    latch_pulse();
    chk(trig_cnt == 1, "R8 compare on rising latch", trig_cnt, 1);
    ext_data = 1'b1; wait_n(3);
    ext_clk = 1'b1; ext_latch = 1'b1;
    wait_n(4);
    chk(trig_cnt == 2, "R8 same-cycle latch uses prior contents", trig_cnt, 2);
    ext_clk = 1'b0; ext_latch = 1'b0; wait_n(5);
    latch_pulse();
    chk(trig_cnt == 2, "R8 new bit landed, no match", trig_cnt, 2);
  endtask

  task automatic t_latch_fall();
    setup(1'b1, 1'b0, 32'hA, 32'hF, 4);
    cfg_latch_en = 1'b1; cfg_latch_falling = 1'b1; ext_latch = 1'b1; wait_n(5);
    send_bits(32'hA, 4);
    chk(trig_cnt == 0, "R8 rising latch ignored in falling mode", trig_cnt, 0);
    latch_pulse();
    chk(trig_cnt == 1, "R8 compare on falling latch", trig_cnt, 1);
  endtask

  task automatic t_internal();
    setup(1'b0, 1'b0, 32'hF, 32'hF, 4);
    cfg_qual_en = 1'b1; cfg_qual_sel = 6'b00_00_01; ext_qual = 3'b000;
    cfg_latch_en = 1'b1; ext_data = 1'b1;
    wait_n(64);
    chk(trig_cnt >= 10, "R1 internal rate triggers, qual/latch ignored", trig_cnt, 10);
    chk(interval == 4, "R1 strobe period 4", interval, 4);
    cfg_rate_inc = 32'h2000_0000;
    wait_n(64);
    chk(interval == 8, "R1 strobe period 8", interval, 8);
    chk(dbl_cnt == 0, "R10 single-cycle pulses", dbl_cnt, 0);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    cfg_ext_clk_en = 1'b1; cfg_clk_falling = 1'b0; cfg_rate_inc = '0;
    cfg_qual_en = 1'b0; cfg_qual_sel = '0; cfg_qual_or = 1'b0;
    cfg_latch_en = 1'b0; cfg_latch_falling = 1'b0;
    cfg_pattern = '0; cfg_mask = '0; cfg_len = 6'd1;
    ext_clk = 1'b0; ext_data = 1'b0; ext_latch = 1'b0; ext_qual = '0;
    wait_n(4);
    rst = 1'b0;
    wait_n(1);
    t_reset();
    t_basic();
    t_length();
    t_mask();
    t_falling();
    t_qual_and();
    t_qual_or();
    t_qual_allx();
    t_qual_off();
    t_latch();
    t_latch_fall();
    t_internal();
    chk(dbl_cnt == 0, "R10 no back-to-back pulse", dbl_cnt, 0);
    finish_up();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    finish_up();
  end
endmodule